// File: doc/BRIEF.md
# Crossbar-Gated GPIO Port Controller

This block is one eight-pin general-purpose I/O port. It holds an output latch and a per-pin output-mode register. From these, plus an allocation mask supplied by a crossbar, it produces an output-enable and an output-value for each tri-state pad driver. A pin that the crossbar hands to a peripheral drives that peripheral's value, and the latch no longer affects it. A pin handed to a peripheral input never drives at all. A single global enable bit holds every driver off until software has finished setting up the pinout.

Software reaches the port through a small register interface. This has a byte write strobe, a separate single-bit write path into the latch, and a read strobe. A normal read of the data register returns the pad levels, after a two-flop synchronizer. When the read-modify-write strobe is raised with the read, it returns the latch contents instead, so that bit operations do not copy externally driven levels back into the latch.

Top module: `gpio_xbar_port`

## Requirements
- R1: After reset the latch holds all ones, every mode bit is 0, the global enable is 0, and pad_oe and pad_do are all zero.
- R2: While the global enable (bit 0 of register address 2) is 0, pad_oe is all zero regardless of latch, mode and peripheral inputs.
- R3: A read of address 0 with rmw low returns the pad_in levels through a two-flop synchronizer. A level applied before clock edge k can be read by a read strobe sampled at edge k+2, not at edge k+1. This holds for peripheral-owned pins too.
- R4: A read of address 0 with rmw high returns the latch contents.
- R5: A pin with its periph_own bit set, and its periph_in_only bit clear, takes its output value from periph_out. Byte and bit writes to the latch do not change what it drives.
- R6: A pin with both periph_own and periph_in_only set has pad_oe 0, whatever its latch and mode bits hold.
- R7: Mode bit 1 is push-pull: pad_oe is 1 and pad_do equals the pin's data value.
- R8: Mode bit 0 is open-drain: pad_do is 0, and pad_oe is 1 for data 0 and 0 for data 1.
- R9: A byte write to address 0 loads the latch. A bit write (bit_wr) sets only the latch bit at bit_idx to bit_val, and this takes priority over a byte write in the same cycle.
- R10: Address 1 reads and writes the mode register, address 2 holds the enable in bit 0 and reads 0 in the other bits, and address 3 reads as zero. Read data appears with rd_valid one clock after the read strobe.
- R11: pad_oe and pad_do are registered. They reflect the register state and peripheral inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register select: 0 data, 1 mode, 2 enable, 3 none |
| wdata | input | 8 | Byte write data |
| rmw | input | 1 | Read-modify-write qualifier for data reads |
| bit_wr | input | 1 | Single-bit latch write strobe |
| bit_idx | input | 3 | Latch bit index for bit writes |
| bit_val | input | 1 | Value written by a bit write |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | rdata valid |
| pad_in | input | 8 | Sampled pad levels |
| periph_own | input | 8 | Pins allocated to a peripheral |
| periph_out | input | 8 | Peripheral output values |
| periph_in_only | input | 8 | Allocated pins that carry a peripheral input |
| pad_oe | output | 8 | Pad output enables |
| pad_do | output | 8 | Pad output values |

## Verification
The bench loads push-pull and open-drain patterns into the latch while the global enable is clear. A design that gated only some drivers, or gated the value instead of the enable, would show a nonzero pad_oe. It writes the latch under peripheral-owned pins, both by byte and by bit, and checks that those pins keep the peripheral level. An override that leaked the latch would flip them. It also reads a pad one cycle too early to prove the synchronizer depth, and issues rmw reads while the pad and latch differ, which exposes a swapped read-path select. Input-only allocations are paired with push-pull mode and latch zero, the setting most likely to drive a pad that must stay released.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [1:0] {
    REG_DATA = 2'd0,
    REG_MODE = 2'd1,
    REG_XEN  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [W-1:0]  wdata,
  input  logic          bit_wr,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  latch_q,
  output logic [W-1:0]  mode_q,
  output logic          xen_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '1;
      mode_q  <= '0;
      xen_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (reg_sel_e'(addr))
          REG_DATA: latch_q <= wdata;
          REG_MODE: mode_q  <= wdata;
          REG_XEN:  xen_q   <= wdata[0];
          default:  ;
        endcase
      end
      if (bit_wr) latch_q[bit_idx] <= bit_val;
    end
  end

  // R9
  bit_write_chk: assert property (@(posedge clk) disable iff (rst)
    $past(bit_wr) && !$past(rst) |-> latch_q[$past(bit_idx)] == $past(bit_val));
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) stg[0] <= rst ? '0 : d;
      end else begin : g_next
        always_ff @(posedge clk) stg[s] <= rst ? '0 : stg[s-1];
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_port_drive.sv
module gpio_port_drive #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         xen,
  input  logic [W-1:0] latch,
  input  logic [W-1:0] mode,
  input  logic [W-1:0] own,
  input  logic [W-1:0] pout,
  input  logic [W-1:0] in_only,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_do
);
  logic [W-1:0] oe_n, do_n;

  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic val, blocked;
      always_comb begin
        blocked = !xen || (own[i] && in_only[i]);
        val     = own[i] ? pout[i] : latch[i];
        if (blocked) begin
          oe_n[i] = 1'b0;
          do_n[i] = 1'b0;
        end else if (mode[i]) begin
          oe_n[i] = 1'b1;
          do_n[i] = val;
        end else begin
          oe_n[i] = !val;
          do_n[i] = 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe <= '0;
      pad_do <= '0;
    end else begin
      pad_oe <= oe_n;
      pad_do <= do_n;
    end
  end

  // R2
  gate_off_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(xen) |-> pad_oe == '0);
  // R6
  in_only_off_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe & $past(own & in_only)) == '0);
  // R8
  od_no_high_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_do & ~$past(mode)) == '0);
  // R7
  pp_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    $past(xen) |-> (pad_oe & $past(mode & ~(own & in_only))) == $past(mode & ~(own & in_only)));
  // R5
  periph_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(xen) |-> ((pad_do ^ $past(pout)) & $past(own & mode & ~in_only)) == '0);
endmodule

// File: rtl/gpio_xbar_port.sv
module gpio_xbar_port
  import gpio_port_pkg::*;
#(
  parameter int W  = 8,
  parameter int IW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    addr,
  input  logic [W-1:0]  wdata,
  input  logic          rmw,
  input  logic          bit_wr,
  input  logic [IW-1:0] bit_idx,
  input  logic          bit_val,
  output logic [W-1:0]  rdata,
  output logic          rd_valid,
  input  logic [W-1:0]  pad_in,
  input  logic [W-1:0]  periph_own,
  input  logic [W-1:0]  periph_out,
  input  logic [W-1:0]  periph_in_only,
  output logic [W-1:0]  pad_oe,
  output logic [W-1:0]  pad_do
);
  logic [W-1:0] latch_q, mode_q, pin_s;
  logic         xen_q;

  gpio_port_regs #(.W(W), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val),
    .latch_q(latch_q), .mode_q(mode_q), .xen_q(xen_q)
  );

  gpio_port_sync #(.W(W), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_s)
  );

  gpio_port_drive #(.W(W)) u_drive (
    .clk(clk), .rst(rst), .xen(xen_q), .latch(latch_q), .mode(mode_q),
    .own(periph_own), .pout(periph_out), .in_only(periph_in_only),
    .pad_oe(pad_oe), .pad_do(pad_do)
  );

  logic [W-1:0] rd_mux;
  always_comb begin
    case (reg_sel_e'(addr))
      REG_DATA: rd_mux = rmw ? latch_q : pin_s;
      REG_MODE: rd_mux = mode_q;
      REG_XEN:  rd_mux = {{(W-1){1'b0}}, xen_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end

  // R4
  rmw_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == REG_DATA && rmw) && !$past(rst) |-> rdata == $past(latch_q));
  // R3
  pin_read_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_en && addr == REG_DATA && !rmw) && !$past(rst) |-> rdata == $past(pin_s));
  // R10
  valid_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> rd_valid == $past(rd_en));
endmodule

// File: tb/gpio_xbar_port_bench.sv
module gpio_xbar_port_bench;
  localparam int W = 8;
  localparam int IW = 3;
  localparam int MAX_CYC = 20000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 0, rd_en = 0, rmw = 0, bit_wr = 0, bit_val = 0;
  logic [1:0] addr = 0;
  logic [W-1:0] wdata = 0, pad_in = 0, periph_own = 0, periph_out = 0, periph_in_only = 0;
  logic [IW-1:0] bit_idx = 0;
  logic [W-1:0] rdata, pad_oe, pad_do;
  logic rd_valid;

  always #5 clk = ~clk;

  gpio_xbar_port #(.W(W), .IW(IW)) u_gpio_xbar_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rmw(rmw), .bit_wr(bit_wr), .bit_idx(bit_idx), .bit_val(bit_val),
    .rdata(rdata), .rd_valid(rd_valid), .pad_in(pad_in), .periph_own(periph_own),
    .periph_out(periph_out), .periph_in_only(periph_in_only),
    .pad_oe(pad_oe), .pad_do(pad_do)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  logic [W-1:0] m_latch = '1, m_mode = '0;
  logic m_xen = 0;
  logic [W-1:0] exp_q[$];
  string tag_q[$];

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected pad outputs from the tracked register state and crossbar inputs.
  task automatic check_pads(string tag);
    logic [W-1:0] eoe, edo;
    for (int i = 0; i < W; i++) begin
      logic v;
      v = periph_own[i] ? periph_out[i] : m_latch[i];
      if (!m_xen || (periph_own[i] && periph_in_only[i])) begin
        eoe[i] = 0; edo[i] = 0;
      end else if (m_mode[i]) begin
        eoe[i] = 1; edo[i] = v;
      end else begin
        eoe[i] = !v; edo[i] = 0;
      end
    end
    chk({tag, " oe"}, pad_oe, eoe);
    chk({tag, " do"}, pad_do, edo);
  endtask

  // All driver tasks are entered at a falling edge.
  task automatic wr(logic [1:0] a, logic [W-1:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
    if (a == 2'd0) m_latch = d;
    if (a == 2'd1) m_mode = d;
    if (a == 2'd2) m_xen = d[0];
  endtask

  task automatic bwr(logic [IW-1:0] i, logic v);
    bit_idx = i; bit_val = v; bit_wr = 1;
    @(negedge clk);
    bit_wr = 0;
    m_latch[i] = v;
  endtask

  task automatic rd(logic [1:0] a, logic r, logic [W-1:0] exp, string tag);
    exp_q.push_back(exp); tag_q.push_back(tag);
    addr = a; rmw = r; rd_en = 1;
    @(negedge clk);
    rd_en = 0; rmw = 0;
  endtask

  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R10 unexpected rd_valid actual=%h expected=none", rdata);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check_pads("R1 reset");
    rd(2'd0, 1, 8'hFF, "R1 latch reset");
    rd(2'd1, 0, 8'h00, "R1 mode reset");
    rd(2'd2, 0, 8'h00, "R1 enable reset");

    wr(2'd1, 8'hFF);
    wr(2'd0, 8'h00);
    @(negedge clk);
    check_pads("R2 gated");
    chk("R2 oe zero", pad_oe, 8'h00);

    wr(2'd2, 8'h01);
    @(negedge clk);
    check_pads("R7 pp zeros");
    wr(2'd0, 8'hA5);
    @(negedge clk);
    check_pads("R7 pp A5");
    chk("R7 oe", pad_oe, 8'hFF);

    wr(2'd1, 8'h0F);
    @(negedge clk);
    check_pads("R8 mixed");
    chk("R8 oe", pad_oe, 8'h5F);
    chk("R8 do", pad_do, 8'h05);
    rd(2'd1, 0, 8'h0F, "R10 mode read");

    bwr(3'd6, 1'b1);
    rd(2'd0, 1, 8'hE5, "R9 bit set");
    wdata = 8'h00; addr = 2'd0; wr_en = 1; bit_idx = 3'd1; bit_val = 1; bit_wr = 1;
    @(negedge clk);
    wr_en = 0; bit_wr = 0; m_latch = 8'h02;
    rd(2'd0, 1, 8'h02, "R9 bit over byte");

    periph_own = 8'h03; periph_out = 8'h02;
    @(negedge clk);
    check_pads("R5 owned");
    wr(2'd0, 8'hFD);
    @(negedge clk);
    check_pads("R5 byte ignored");
    chk("R5 low bits", pad_do & 8'h03, 8'h02);
    bwr(3'd1, 1'b0);
    @(negedge clk);
    chk("R5 bit ignored", pad_do & 8'h03, 8'h02);
    rd(2'd0, 1, 8'hFD, "R4 latch under owned");

    periph_own = 8'h0F; periph_in_only = 8'h08; periph_out = 8'h00;
    wr(2'd0, 8'h00);
    @(negedge clk);
    check_pads("R6 input only");
    chk("R6 pin3 off", pad_oe & 8'h08, 8'h00);

    pad_in = 8'h3C;
    @(negedge clk); @(negedge clk);
    rd(2'd0, 0, 8'h3C, "R3 pad read");
    rd(2'd0, 1, 8'h00, "R4 rmw read");
    pad_in = 8'hC3;
    @(negedge clk);
    rd(2'd0, 0, 8'h3C, "R3 one cycle early");
    rd(2'd0, 0, 8'hC3, "R3 after two");

    periph_out = 8'h07;
    #1 check_pads_hold();
    @(negedge clk);
    check_pads("R11 after edge");

    wr(2'd2, 8'h00);
    @(negedge clk);
    check_pads("R2 disabled again");
    rd(2'd2, 0, 8'h00, "R10 enable read");
    rd(2'd3, 0, 8'h00, "R10 empty address");
    @(negedge clk); @(negedge clk);
    chk("R10 queue drained", 8'(exp_q.size()), 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // pad_do must not react before the next clock edge.
  task automatic check_pads_hold();
    chk("R11 before edge", pad_do & 8'h07, 8'h00);
  endtask
endmodule